// File: doc/BRIEF.md
# Status Word Debug Capture and Force

This block sits in the path of the 160-bit status word that accompanies each packet into a packet processor. It registers the word once on its way through and, for debug, can replace individual named fields of the word with values held in software-writable registers. Each field has its own enable bit, and a single global enable gates them all, so a field is overridden only when both are set.

Alongside the forcing path, the block keeps a snapshot of the most recent valid word (after forcing) in five 32-bit capture registers. When a word whose error flag is set passes, the snapshot freezes and further words are ignored until software releases it with a write. Because the error flag is judged after forcing, software can freeze a snapshot on demand by forcing the error field.

The status word is treated as five 32-bit words: word 0 holds bits [31:0], word 4 holds bits [159:128]. The force value registers use the same layout as the word, so force register k overlays word k bit for bit.

Top module: `swdbg_top`

## Requirements
- R1: After synchronous reset `out_valid` is 0, `out_word` is 0, and every register address reads 0 (capture, force values, field enables, global enable).
- R2: `out_valid` and `out_word` follow `in_valid` and `in_word` one clock later; with the global enable at 0 `out_word` equals the input word of the previous cycle bit for bit.
- R3: With the global enable at 1, a field is taken from the force registers exactly when its enable bit is 1. Field enable bit -> status bits: 0 -> [143:96]; 1 -> [8:0]; 2 -> [9]; 3 -> [10]; 4 -> [14:11]; 5 -> [60:32]; 6 -> [16:15]; 7 -> [17]; 8 -> [25:18]; 9 -> [71:64]; 10 -> [85:72]; 11 -> [86]; 12 -> [87]; 13 -> [88] (error flag); 14 -> [89].
- R4: With the global enable at 0, field enable bits and force values have no effect on `out_word`.
- R5: Status bits outside every field ([31:26], [63:61], [95:90], [159:144]) are never forced; force register writes keep only field bits, so those bits read back as 0.
- R6: While not frozen, the capture registers take the forced word of every cycle with `in_valid` high one clock later; cycles with `in_valid` low leave them unchanged.
- R7: A captured word whose status bit 88 is 1 after forcing freezes the capture; following words are not captured.
- R8: A write to address 0 with data bit 0 at 1 releases a frozen capture; a write there with bit 0 at 0, or a write to addresses 1 to 4, changes nothing.
- R9: When a release write and a valid word arrive in the same cycle, the word is judged against the state before the write: if frozen it is not captured and the capture is released; if not frozen it is captured and an error flag freezes it.
- R10: Register map (4-bit address, 32-bit data): 0-4 capture words 0-4 (read only), 5-9 force values for words 0-4, 10 field enables in bits [14:0], 11 global enable in bit 0, 12-15 read 0.
- R11: A force register write takes effect for words arriving in later cycles; a word arriving in the same cycle as the write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input status word valid |
| in_word | input | 160 | Input status word |
| out_valid | output | 1 | Output status word valid, one cycle after input |
| out_word | output | 160 | Output status word after field forcing |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |

## Verification
The two functions that can fall in one cycle are the software release of a frozen capture and the arrival of a valid word, and likewise a force register write and a valid word. The bench drives a release write together with a valid word both while frozen and while free (the latter with the error flag set), and writes a force value in the same cycle as a word. A behavioural model that updates once per clock from the same driven inputs predicts the capture contents, the freeze state seen through later captures, and the forced output, and every cycle's outputs and read data are compared against it.

// File: rtl/swdbg_pkg.sv
package swdbg_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 5;
    localparam int STATUS_W  = WORD_W * NUM_WORDS;
    localparam int FEN_W     = 15;
    localparam int ADDR_W    = 4;

    // Register address plan
    localparam int A_CAP0 = 0;
    localparam int A_FRC0 = A_CAP0 + NUM_WORDS;
    localparam int A_FEN  = A_FRC0 + NUM_WORDS;
    localparam int A_GEN  = A_FEN + 1;

    // Error flag location inside the status word
    localparam int ERR_WORD = 2;
    localparam int ERR_POS  = 24;
    localparam int ERR_BIT  = ERR_WORD * WORD_W + ERR_POS;

    // Field enable bit numbers
    localparam int FE_WIDE   = 0;
    localparam int FE_DOFF   = 1;
    localparam int FE_PMAC   = 2;
    localparam int FE_TCLS   = 3;
    localparam int FE_SPOOL  = 4;
    localparam int FE_BPTR   = 5;
    localparam int FE_PRE2   = 6;
    localparam int FE_TSTAMP = 7;
    localparam int FE_PORT   = 8;
    localparam int FE_POLICY = 9;
    localparam int FE_PLEN   = 10;
    localparam int FE_ROUND2 = 11;
    localparam int FE_HDRM   = 12;
    localparam int FE_ERR    = 13;
    localparam int FE_DISC   = 14;

    typedef logic [WORD_W-1:0]           word_t;
    typedef word_t [NUM_WORDS-1:0]       status_t;
    typedef logic [FEN_W-1:0]            fen_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        word_t             wdata;
    } reg_req_t;

    // Bits of word w that are overridden for a given set of field enables
    function automatic word_t word_mask(input int unsigned w, input fen_t en);
        word_t m;
        case (w)
            0: m = {6'b0, {8{en[FE_PORT]}}, en[FE_TSTAMP], {2{en[FE_PRE2]}},
                    {4{en[FE_SPOOL]}}, en[FE_TCLS], en[FE_PMAC], {9{en[FE_DOFF]}}};
            1: m = {3'b0, {29{en[FE_BPTR]}}};
            2: m = {6'b0, en[FE_DISC], en[FE_ERR], en[FE_HDRM], en[FE_ROUND2],
                    {14{en[FE_PLEN]}}, {8{en[FE_POLICY]}}};
            3: m = {32{en[FE_WIDE]}};
            4: m = {16'b0, {16{en[FE_WIDE]}}};
            default: m = '0;
        endcase
        return m;
    endfunction

    // Bits of word w that belong to any field
    function automatic word_t impl_mask(input int unsigned w);
        return word_mask(w, '1);
    endfunction

    // Status bits that belong to no field
    function automatic logic [STATUS_W-1:0] spare_bits();
        logic [STATUS_W-1:0] s;
        for (int w = 0; w < NUM_WORDS; w++) begin
            s[w*WORD_W +: WORD_W] = ~impl_mask(w);
        end
        return s;
    endfunction

endpackage

// File: rtl/swdbg_regs.sv
module swdbg_regs
    import swdbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req,
    output status_t  frc,
    output fen_t     fen,
    output logic     gen,
    output logic     release_req
);

    word_t frc_q [NUM_WORDS];
    fen_t  fen_q;
    logic  gen_q;

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_frc
            localparam word_t KEEP = impl_mask(w);
            always_ff @(posedge clk) begin
                if (rst) begin
                    frc_q[w] <= '0;
                end else if (req.we && req.addr == ADDR_W'(A_FRC0 + w)) begin
                    frc_q[w] <= req.wdata & KEEP;
                end
            end
            assign frc[w] = frc_q[w];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            fen_q <= '0;
            gen_q <= 1'b0;
        end else if (req.we) begin
            if (req.addr == ADDR_W'(A_FEN)) fen_q <= req.wdata[FEN_W-1:0];
            if (req.addr == ADDR_W'(A_GEN)) gen_q <= req.wdata[0];
        end
    end

    assign fen         = fen_q;
    assign gen         = gen_q;
    assign release_req = req.we && req.addr == ADDR_W'(A_CAP0) && req.wdata[0];

endmodule

// File: rtl/swdbg_force.sv
module swdbg_force
    import swdbg_pkg::*;
(
    input  status_t raw,
    input  status_t frc,
    input  fen_t    fen,
    input  logic    gen,
    output status_t cooked
);

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            word_t sel;
            assign sel       = gen ? word_mask(w, fen) : '0;
            assign cooked[w] = (raw[w] & ~sel) | (frc[w] & sel);
        end
    endgenerate

endmodule

// File: rtl/swdbg_capture.sv
module swdbg_capture
    import swdbg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid,
    input  status_t word,
    input  logic    release_req,
    output status_t snap,
    output logic    frozen
);

    status_t snap_q;
    logic    frozen_q;
    logic    take;

    assign take = valid && !frozen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q   <= '0;
            frozen_q <= 1'b0;
        end else begin
            if (take) snap_q <= word;
            if (frozen_q) begin
                if (release_req) frozen_q <= 1'b0;
            end else if (take && word[ERR_WORD][ERR_POS]) begin
                frozen_q <= 1'b1;
            end
        end
    end

    assign snap   = snap_q;
    assign frozen = frozen_q;

endmodule

// File: rtl/swdbg_top.sv
module swdbg_top
    import swdbg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [STATUS_W-1:0] in_word,
    output logic                out_valid,
    output logic [STATUS_W-1:0] out_word,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata
);

    reg_req_t            req;
    status_t             frc;
    fen_t                fen;
    logic                glob_en;
    logic                rel;
    status_t             raw;
    status_t             cooked;
    status_t             cap_s;
    logic                cap_frozen;
    logic [STATUS_W-1:0] cap_flat;
    logic                ov_q;
    status_t             ow_q;

    assign req = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};
    assign raw = in_word;

    swdbg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .frc         (frc),
        .fen         (fen),
        .gen         (glob_en),
        .release_req (rel)
    );

    swdbg_force u_force (
        .raw    (raw),
        .frc    (frc),
        .fen    (fen),
        .gen    (glob_en),
        .cooked (cooked)
    );

    swdbg_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .valid       (in_valid),
        .word        (cooked),
        .release_req (rel),
        .snap        (cap_s),
        .frozen      (cap_frozen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q <= 1'b0;
            ow_q <= '0;
        end else begin
            ov_q <= in_valid;
            ow_q <= cooked;
        end
    end

    assign out_valid = ov_q;
    assign out_word  = ow_q;
    assign cap_flat  = cap_s;

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_addr == ADDR_W'(A_CAP0 + w)) reg_rdata = cap_s[w];
            if (reg_addr == ADDR_W'(A_FRC0 + w)) reg_rdata = frc[w];
        end
        if (reg_addr == ADDR_W'(A_FEN)) reg_rdata = WORD_W'(fen);
        if (reg_addr == ADDR_W'(A_GEN)) reg_rdata = WORD_W'(glob_en);
    end

endmodule

// File: rtl/swdbg_chk.sv
module swdbg_chk
    import swdbg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [STATUS_W-1:0] in_word,
    input logic                out_valid,
    input logic [STATUS_W-1:0] out_word,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                wbit0,
    input logic                gen,
    input logic                frozen,
    input logic [STATUS_W-1:0] cap
);

    localparam logic [STATUS_W-1:0] SPARE = spare_bits();

    // R2: valid follows input one cycle later
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_delay_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4: global enable off means plain pass-through
    p_no_force_off_r4: assert property (@(posedge clk) disable iff (rst)
        !gen |=> out_word == $past(in_word));

    // R5: bits outside all fields pass untouched
    p_spare_pass_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_word & SPARE) == ($past(in_word) & SPARE));

    // R6: a captured word equals the word sent out
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && !frozen |=> cap == out_word);

    // R7: freeze follows the error flag of the captured word
    p_freeze_set_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && !frozen |=> frozen == out_word[ERR_BIT]);

    // R7: frozen capture holds without a release
    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (rst)
        frozen && !(reg_we && reg_addr == ADDR_W'(A_CAP0) && wbit0) |=> frozen && $stable(cap));

    // R8 R9: release write clears the freeze
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        frozen && reg_we && reg_addr == ADDR_W'(A_CAP0) && wbit0 |=> !frozen && $stable(cap));

endmodule

bind swdbg_top swdbg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_word  (out_word),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wbit0     (reg_wdata[0]),
    .gen       (glob_en),
    .frozen    (cap_frozen),
    .cap       (cap_flat)
);

// File: tb/sim_swdbg_top.sv
`timescale 1ns/1ps
module sim_swdbg_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [159:0] in_word = '0;
    logic         out_valid;
    logic [159:0] out_word;
    logic         reg_we = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;

    always #4 clk = ~clk;

    swdbg_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_word(out_word), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // Reference model state
    logic [159:0] m_out;
    logic         m_ov;
    logic [31:0]  m_frc [5];
    logic [14:0]  m_fen;
    logic         m_gen;
    logic [159:0] m_cap;
    bit           m_frozen;
    int           f_lo [15];
    int           f_w  [15];
    logic [159:0] m_impl;

    task automatic chk(input string what, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [159:0] apply_force(input logic [159:0] w);
        logic [159:0] r  = w;
        logic [159:0] fv = {m_frc[4], m_frc[3], m_frc[2], m_frc[1], m_frc[0]};
        if (m_gen) begin
            for (int f = 0; f < 15; f++) begin
                if (m_fen[f]) begin
                    for (int b = 0; b < f_w[f]; b++) r[f_lo[f]+b] = fv[f_lo[f]+b];
                end
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] rd_exp(input logic [3:0] a);
        if (a < 5)   return m_cap[a*32 +: 32];
        if (a < 10)  return m_frc[a-5];
        if (a == 10) return {17'b0, m_fen};
        if (a == 11) return {31'b0, m_gen};
        return 32'h0;
    endfunction

    task automatic model_step(input bit v, input logic [159:0] w, input bit we,
                              input logic [3:0] a, input logic [31:0] d);
        logic [159:0] f = apply_force(w);
        bit rel = we && (a == 0) && d[0];
        m_out = f;
        m_ov  = v;
        if (m_frozen) begin
            if (rel) m_frozen = 0;
        end else if (v) begin
            m_cap = f;
            if (f[88]) m_frozen = 1;
        end
        if (we) begin
            if (a >= 5 && a < 10) m_frc[a-5] = d & m_impl[(a-5)*32 +: 32];
            if (a == 10) m_fen = d[14:0];
            if (a == 11) m_gen = d[0];
        end
    endtask

    task automatic cyc(input bit v, input logic [159:0] w, input bit we,
                       input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        chk("out_valid", {159'b0, out_valid}, {159'b0, m_ov});
        chk("out_word", out_word, m_out);
        chk("reg_rdata", {128'b0, reg_rdata}, {128'b0, rd_exp(reg_addr)});
        in_valid  = v;
        in_word   = w;
        reg_we    = we;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        model_step(v, w, we, a, d);
    endtask

    task automatic idle(input logic [3:0] a);
        cyc(1'b0, '0, 1'b0, a, 32'h0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b0, '0, 1'b1, a, d);
    endtask

    function automatic logic [159:0] rnd_word(input bit err);
        logic [159:0] r = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        r[88] = err;
        return r;
    endfunction

    task automatic read_caps();
        for (int a = 0; a < 5; a++) idle(4'(a));
        idle(4'd0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        // field table (bit positions from the requirements)
        f_lo[0]=96;  f_w[0]=48;  f_lo[1]=0;   f_w[1]=9;   f_lo[2]=9;   f_w[2]=1;
        f_lo[3]=10;  f_w[3]=1;   f_lo[4]=11;  f_w[4]=4;   f_lo[5]=32;  f_w[5]=29;
        f_lo[6]=15;  f_w[6]=2;   f_lo[7]=17;  f_w[7]=1;   f_lo[8]=18;  f_w[8]=8;
        f_lo[9]=64;  f_w[9]=8;   f_lo[10]=72; f_w[10]=14; f_lo[11]=86; f_w[11]=1;
        f_lo[12]=87; f_w[12]=1;  f_lo[13]=88; f_w[13]=1;  f_lo[14]=89; f_w[14]=1;
        m_impl = '0;
        for (int f = 0; f < 15; f++)
            for (int b = 0; b < f_w[f]; b++) m_impl[f_lo[f]+b] = 1'b1;
        m_out = '0; m_ov = 0; m_fen = '0; m_gen = 0; m_cap = '0; m_frozen = 0;
        for (int i = 0; i < 5; i++) m_frc[i] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 R10: reset state and register map, including unmapped addresses
        cur_req = "R1 R10";
        for (int a = 0; a < 16; a++) idle(4'(a));

        // R2: pass-through with forcing off
        cur_req = "R2";
        for (int i = 0; i < 20; i++) cyc(1'b1, rnd_word(0), 1'b0, 4'(i % 12), 32'h0);
        cyc(1'b0, rnd_word(0), 1'b0, 4'd0, 32'h0);
        idle(4'd0);

        // R4: enables set but global enable off
        cur_req = "R4";
        for (int a = 5; a < 10; a++) wr(4'(a), 32'hFFFF_FFFF);
        wr(4'd10, 32'h0000_7FFF);
        for (int i = 0; i < 10; i++) cyc(1'b1, rnd_word(0), 1'b0, 4'(5 + i % 6), 32'h0);

        // R5: readback masks, spare bits never forced (all fields forced)
        cur_req = "R5";
        wr(4'd11, 32'h1);
        for (int a = 5; a < 12; a++) idle(4'(a));
        for (int i = 0; i < 8; i++) cyc(1'b1, rnd_word(i[0]), 1'b0, 4'd0, 32'h0);

        // R3: each field forced on its own
        cur_req = "R3";
        wr(4'd0, 32'h1);
        wr(4'd5, 32'h0A5C_3E71);
        wr(4'd6, 32'h1357_9BDF);
        wr(4'd7, 32'h02C4_8A1E);
        wr(4'd8, 32'hDEAD_BEEF);
        wr(4'd9, 32'h0000_F00D);
        for (int f = 0; f < 15; f++) begin
            wr(4'd10, 32'(1) << f);
            for (int i = 0; i < 3; i++) cyc(1'b1, rnd_word(0), 1'b0, 4'd10, 32'h0);
        end
        wr(4'd10, 32'h0000_7FFF);
        for (int i = 0; i < 4; i++) cyc(1'b1, rnd_word(0), 1'b0, 4'd2, 32'h0);

        // R6: capture of valid words only
        cur_req = "R6";
        wr(4'd11, 32'h0);
        wr(4'd0, 32'h1);
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, rnd_word(0), 1'b0, 4'(i % 5), 32'h0);
            cyc(1'b0, rnd_word(1), 1'b0, 4'(i % 5), 32'h0);
        end
        read_caps();

        // R7: error word freezes capture
        cur_req = "R7";
        cyc(1'b1, rnd_word(1), 1'b0, 4'd2, 32'h0);
        for (int i = 0; i < 4; i++) cyc(1'b1, rnd_word(0), 1'b0, 4'(i), 32'h0);
        read_caps();

        // R8: non-release writes leave the freeze in place
        cur_req = "R8";
        wr(4'd0, 32'hFFFF_FFFE);
        for (int a = 1; a < 5; a++) wr(4'(a), 32'hFFFF_FFFF);
        cyc(1'b1, rnd_word(0), 1'b0, 4'd1, 32'h0);
        read_caps();
        wr(4'd0, 32'h1);
        cyc(1'b1, rnd_word(0), 1'b0, 4'd0, 32'h0);
        read_caps();

        // R7: forced error flag freezes capture
        cur_req = "R7";
        wr(4'd7, 32'h0100_0000);
        wr(4'd10, 32'h0000_2000);
        wr(4'd11, 32'h1);
        cyc(1'b1, rnd_word(0), 1'b0, 4'd2, 32'h0);
        cyc(1'b1, rnd_word(0), 1'b0, 4'd2, 32'h0);
        read_caps();
        wr(4'd11, 32'h0);

        // R9: release and valid word in one cycle
        cur_req = "R9";
        cyc(1'b1, rnd_word(0), 1'b1, 4'd0, 32'h1);
        cyc(1'b1, rnd_word(1), 1'b0, 4'd0, 32'h0);
        cyc(1'b1, rnd_word(0), 1'b1, 4'd0, 32'h1);
        cyc(1'b1, rnd_word(0), 1'b0, 4'd0, 32'h0);
        read_caps();
        cyc(1'b1, rnd_word(1), 1'b1, 4'd0, 32'h1);
        cyc(1'b1, rnd_word(0), 1'b0, 4'd2, 32'h0);
        read_caps();

        // R11: force write in the same cycle as a word
        cur_req = "R11";
        wr(4'd0, 32'h1);
        wr(4'd5, 32'h0);
        wr(4'd10, 32'h0000_0100);
        wr(4'd11, 32'h1);
        cyc(1'b1, rnd_word(0), 1'b1, 4'd5, 32'h03FC_0000);
        cyc(1'b1, rnd_word(0), 1'b0, 4'd5, 32'h0);
        cyc(1'b1, rnd_word(0), 1'b1, 4'd11, 32'h0);
        cyc(1'b1, rnd_word(0), 1'b0, 4'd11, 32'h0);
        idle(4'd0);
        idle(4'd0);

        summary();
        $finish;
    end

endmodule